// File: doc/BRIEF.md
# Edge-Timestamping Period Meter

This block measures the period of a digitised waveform that reaches it as two comparator outputs. One comparator marks the upper threshold and the other the lower threshold. After a two-flop synchroniser, the two feed a set/reset state register, so the gap between the thresholds acts as hysteresis. Each rising transition of that state is stamped with the value of a free-running, wrapping timestamp counter. The edges are counted until the next poll.

A poll comes either from a strobe input or from an internal tick that fires every `TICK_DIV` clock cycles (one millisecond in the target system). A poll closes the current window. If the window held no edges, the block reports a "no edge" result at once. Otherwise it divides the span between the last edge of the previous non-empty window and the last edge of this window by the number of edges, using a sequential divider. At low input rates every period is reported individually. At high rates the result becomes an average over all edges in the window, without any extra storage.

Top module: `period_meter`

## Requirements
- R1: The state register is set when the synchronised set input is 1 and the clear input is 0. It is cleared when the clear input is 1 and the set input is 0, and it holds when both are 1 or both are 0. A further set pulse while the state is already high produces no edge.
- R2: Each rising transition of the state register is stamped with a `TS_W`-bit counter that increments every clock and wraps. Spans are taken modulo 2^`TS_W`, so a span shorter than 2^`TS_W` cycles is exact even across a wrap.
- R3: The window edge count saturates at 2^`CNT_W`-1. An edge arriving at that value sets `overflow_o`, which stays 1 until reset.
- R4: A poll occurs in every cycle where `poll_i` is 1, and once every `TICK_DIV` cycles from the internal tick.
- R5: A poll of a window with zero counted edges produces a `valid_o` pulse with `no_edge_o`=1 and `edge_cnt_o`=0, and leaves `period_o` unchanged.
- R6: A window with exactly one edge reports `period_o` equal to that edge's timestamp minus the reference timestamp.
- R7: A window with n>1 edges reports `edge_cnt_o`=n and `period_o`=floor(span/n), with `no_edge_o`=0.
- R8: The first edge after reset is not counted. It only sets the reference timestamp.
- R9: A poll arriving while the divider is busy is held pending (polls merge, at most one pending) and is serviced once the divider is free.
- R10: `valid_o` is a single-cycle pulse and is never high in two consecutive cycles.
- R11: A poll clears the window count. The reference moves to the window's last edge only when the window had edges, so a span can reach back across empty windows.
- R12: After reset, `valid_o`, `no_edge_o`, `overflow_o`, `period_o` and `edge_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_set_i | input | 1 | Upper-threshold comparator, asynchronous |
| cmp_clr_i | input | 1 | Lower-threshold comparator, asynchronous |
| poll_i | input | 1 | Poll strobe, one poll per high cycle |
| period_o | output | TS_W | Averaged period in clock cycles |
| edge_cnt_o | output | CNT_W | Edges counted in the reported window |
| no_edge_o | output | 1 | Reported window had no edge |
| valid_o | output | 1 | Result pulse |
| overflow_o | output | 1 | Sticky edge-count saturation flag |

## Verification
The bound checker watches, on every cycle, the following properties:
- the state register holding when both threshold inputs are active;
- the saturated count staying put;
- the sticky overflow flag;
- the divider never being started while busy;
- the single-cycle result pulse;
- the count clearing after a poll.

The numerical results can only be shown by the bench's scenarios. These include averaged periods over swept edge counts and spacings that cross counter wraps, the seeding first edge, spans reaching across an empty window, the queued poll, saturation, and the tick interval.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_DONE = 2'd2
    } div_state_e;

    typedef enum logic [1:0] {
        LAT_HOLD = 2'd0,
        LAT_SET  = 2'd1,
        LAT_CLR  = 2'd2
    } latch_act_e;

    function automatic latch_act_e latch_action(input logic set_in, input logic clr_in);
        if (set_in && !clr_in)
            return LAT_SET;
        else if (clr_in && !set_in)
            return LAT_CLR;
        else
            return LAT_HOLD;
    endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pm_tick.sv
module pm_tick #(
    parameter int TICK_DIV = 200000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt_q == LAST);
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/pm_window.sv
module pm_window
    import pm_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_s,
    input  logic             clr_s,
    input  logic             svc,
    output logic             latch_q,
    output logic [CNT_W-1:0] win_cnt,
    output logic [TS_W-1:0]  win_span,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             latch_d;
    logic [TS_W-1:0]  ts_q;
    logic [TS_W-1:0]  ts_ref;
    logic [TS_W-1:0]  ts_last;
    logic             have_ref;
    logic             rise;
    logic [CNT_W-1:0] cnt_base;

    assign rise     = latch_q & ~latch_d;
    assign cnt_base = svc ? '0 : win_cnt;
    assign win_span = ts_last - ts_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= 1'b0;
            latch_d  <= 1'b0;
            ts_q     <= '0;
            ts_ref   <= '0;
            ts_last  <= '0;
            have_ref <= 1'b0;
            win_cnt  <= '0;
            ovf      <= 1'b0;
        end else begin
            ts_q    <= ts_q + TS_W'(1);
            latch_d <= latch_q;
            unique case (latch_action(set_s, clr_s))
                LAT_SET: latch_q <= 1'b1;
                LAT_CLR: latch_q <= 1'b0;
                default: latch_q <= latch_q;
            endcase

            if (svc && (win_cnt != '0))
                ts_ref <= ts_last;
            win_cnt <= cnt_base;

            if (rise) begin
                ts_last <= ts_q;
                if (!have_ref) begin
                    have_ref <= 1'b1;
                    ts_ref   <= ts_q;
                end else if (cnt_base == CNT_MAX) begin
                    ovf <= 1'b1;
                end else begin
                    win_cnt <= cnt_base + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pm_divider.sv
module pm_divider
    import pm_pkg::*;
#(
    parameter int N_W = 32,
    parameter int D_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           busy,
    output logic           done,
    output logic [N_W-1:0] quotient
);
    localparam int IT_W = $clog2(N_W + 1);

    div_state_e     st;
    logic [N_W-1:0] quo;
    logic [D_W-1:0] rem;
    logic [D_W-1:0] dvs;
    logic [IT_W-1:0] left;
    logic [D_W:0]   trial;
    logic [D_W:0]   diff;
    logic           fits;

    assign trial = {rem, quo[N_W-1]};
    assign diff  = trial - {1'b0, dvs};
    assign fits  = (trial >= {1'b0, dvs});

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= DIV_IDLE;
            quo  <= '0;
            rem  <= '0;
            dvs  <= '0;
            left <= '0;
        end else begin
            unique case (st)
                DIV_IDLE: begin
                    if (start) begin
                        quo  <= dividend;
                        dvs  <= divisor;
                        rem  <= '0;
                        left <= IT_W'(N_W);
                        st   <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    if (fits) begin
                        rem <= diff[D_W-1:0];
                        quo <= {quo[N_W-2:0], 1'b1};
                    end else begin
                        rem <= trial[D_W-1:0];
                        quo <= {quo[N_W-2:0], 1'b0};
                    end
                    left <= left - IT_W'(1);
                    if (left == IT_W'(1)) st <= DIV_DONE;
                end
                DIV_DONE: st <= DIV_IDLE;
                default:  st <= DIV_IDLE;
            endcase
        end
    end

    assign busy     = (st != DIV_IDLE);
    assign done     = (st == DIV_DONE);
    assign quotient = quo;
endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int TS_W     = 32,
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 200000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_set_i,
    input  logic             cmp_clr_i,
    input  logic             poll_i,
    output logic [TS_W-1:0]  period_o,
    output logic [CNT_W-1:0] edge_cnt_o,
    output logic             no_edge_o,
    output logic             valid_o,
    output logic             overflow_o
);
    logic             set_s;
    logic             clr_s;
    logic [1:0]       sync_q;
    logic             tick;
    logic             pending;
    logic             want;
    logic             svc;
    logic             latch_q;
    logic [CNT_W-1:0] win_cnt;
    logic [TS_W-1:0]  win_span;
    logic             div_start;
    logic             div_busy;
    logic             div_done;
    logic [TS_W-1:0]  div_quo;
    logic [CNT_W-1:0] cnt_hold;

    pm_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cmp_set_i, cmp_clr_i}),
        .q_o (sync_q)
    );
    assign set_s = sync_q[1];
    assign clr_s = sync_q[0];

    pm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    assign want      = poll_i | tick | pending;
    assign svc       = want & ~div_busy & ~valid_o;
    assign div_start = svc & (win_cnt != '0);

    pm_window #(.TS_W(TS_W), .CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .set_s    (set_s),
        .clr_s    (clr_s),
        .svc      (svc),
        .latch_q  (latch_q),
        .win_cnt  (win_cnt),
        .win_span (win_span),
        .ovf      (overflow_o)
    );

    pm_divider #(.N_W(TS_W), .D_W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (win_span),
        .divisor  (win_cnt),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= 1'b0;
            cnt_hold   <= '0;
            period_o   <= '0;
            edge_cnt_o <= '0;
            no_edge_o  <= 1'b0;
            valid_o    <= 1'b0;
        end else begin
            pending <= want & ~svc;
            valid_o <= 1'b0;
            if (svc) cnt_hold <= win_cnt;
            if (svc && (win_cnt == '0)) begin
                valid_o    <= 1'b1;
                no_edge_o  <= 1'b1;
                edge_cnt_o <= '0;
            end else if (div_done) begin
                valid_o    <= 1'b1;
                no_edge_o  <= 1'b0;
                edge_cnt_o <= cnt_hold;
                period_o   <= div_quo;
            end
        end
    end
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             set_s,
    input logic             clr_s,
    input logic             latch_q,
    input logic             svc,
    input logic             div_start,
    input logic             div_busy,
    input logic             valid_o,
    input logic             no_edge_o,
    input logic             overflow_o,
    input logic [CNT_W-1:0] win_cnt,
    input logic [CNT_W-1:0] edge_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_latch_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (set_s && clr_s) |=> (latch_q == $past(latch_q)));

    p_cnt_sat_r3: assert property (@(posedge clk) disable iff (rst)
        (win_cnt == CNT_MAX && !svc) |=> (win_cnt == CNT_MAX));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
        div_start |-> !div_busy);

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_count_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !no_edge_o) |-> (edge_cnt_o != '0));

    p_window_clear_r11: assert property (@(posedge clk) disable iff (rst)
        svc |=> (win_cnt <= CNT_W'(1)));
endmodule

bind period_meter pm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .set_s      (set_s),
    .clr_s      (clr_s),
    .latch_q    (latch_q),
    .svc        (svc),
    .div_start  (div_start),
    .div_busy   (div_busy),
    .valid_o    (valid_o),
    .no_edge_o  (no_edge_o),
    .overflow_o (overflow_o),
    .win_cnt    (win_cnt),
    .edge_cnt_o (edge_cnt_o)
);

// File: tb/period_meter_tb_top.sv
`timescale 1ns/1ps
module period_meter_tb_top;
    localparam int TS_W  = 12;
    localparam int CNT_W = 4;
    localparam int MODV  = 1 << TS_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cset = 1'b0;
    logic cclr = 1'b0;
    logic poll = 1'b0;
    logic [TS_W-1:0]  period;
    logic [CNT_W-1:0] ecnt;
    logic no_edge, valid, ovf;
    logic [TS_W-1:0]  t_period;
    logic [CNT_W-1:0] t_ecnt;
    logic t_no_edge, t_valid, t_ovf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_e = 0;
    int ref_e = 0;
    bit finished = 0;
    bit prev_valid = 0;
    int back_to_back = 0;

    always #2.5 clk = ~clk;

    period_meter #(.TS_W(TS_W), .CNT_W(CNT_W), .TICK_DIV(1 << 20)) dut_i (
        .clk(clk), .rst(rst), .cmp_set_i(cset), .cmp_clr_i(cclr), .poll_i(poll),
        .period_o(period), .edge_cnt_o(ecnt), .no_edge_o(no_edge),
        .valid_o(valid), .overflow_o(ovf)
    );

    period_meter #(.TS_W(TS_W), .CNT_W(CNT_W), .TICK_DIV(50)) dut_tick_i (
        .clk(clk), .rst(rst), .cmp_set_i(1'b0), .cmp_clr_i(1'b0), .poll_i(1'b0),
        .period_o(t_period), .edge_cnt_o(t_ecnt), .no_edge_o(t_no_edge),
        .valid_o(t_valid), .overflow_o(t_ovf)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && valid && prev_valid) back_to_back++;
        prev_valid <= valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one rising edge, next edge may start gap cycles later
    task automatic edge_gap(input int gap);
        @(negedge clk); cset = 1'b1; last_e = cyc;
        @(negedge clk); cset = 1'b0;
        repeat (2) @(negedge clk);
        cclr = 1'b1;
        @(negedge clk); cclr = 1'b0;
        repeat (gap - 5) @(negedge clk);
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 300; i++) begin
            if (valid) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic poll_expect(input int exp_cnt, input int exp_per, input bit exp_ne, input string tag);
        bit got;
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        wait_valid(got);
        chk(got, {tag, " valid"}, int'(got), 1);
        chk(no_edge == exp_ne, {tag, " no_edge"}, int'(no_edge), int'(exp_ne));
        chk(int'(ecnt) == exp_cnt, {tag, " count"}, int'(ecnt), exp_cnt);
        chk(int'(period) == exp_per, {tag, " period"}, int'(period), exp_per);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int spc [4] = '{7, 13, 100, 523};
        int held;
        int t1;
        bit got;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!valid && !no_edge && !ovf && period == 0 && ecnt == 0, "R12 reset",
            int'({valid, no_edge, ovf}) + int'(period) + int'(ecnt), 0);

        // R5 empty poll with no history
        poll_expect(0, 0, 1'b1, "R5 empty");

        // R8 seed edge only
        edge_gap(10);
        ref_e = last_e;
        poll_expect(0, 0, 1'b1, "R8 seed");

        // R6 / R7 / R2 sweep over counts and spacings, crossing wraps
        held = 0;
        foreach (spc[k]) begin
            for (int n = 1; n <= 6; n++) begin
                int exp_p;
                for (int e = 0; e < n; e++) edge_gap(spc[k]);
                exp_p = ((last_e - ref_e) % MODV) / n;
                poll_expect(n, exp_p, 1'b0, (n == 1) ? "R6 single" : "R7 avg R2");
                ref_e = last_e;
                held = exp_p;
            end
        end

        // R1 hysteresis: repeated set, then both active from low state
        @(negedge clk); cset = 1'b1; last_e = cyc;
        @(negedge clk); cset = 1'b0;
        repeat (2) @(negedge clk);
        cset = 1'b1;
        @(negedge clk); cset = 1'b0;
        repeat (2) @(negedge clk);
        cclr = 1'b1;
        @(negedge clk); cclr = 1'b0;
        repeat (3) @(negedge clk);
        cset = 1'b1; cclr = 1'b1;
        @(negedge clk); cset = 1'b0; cclr = 1'b0;
        repeat (8) @(negedge clk);
        held = (last_e - ref_e) % MODV;
        poll_expect(1, held, 1'b0, "R1 hysteresis");
        ref_e = last_e;

        // R11 span reaching across an empty window; R5 period unchanged
        poll_expect(0, held, 1'b1, "R5 hold");
        edge_gap(40);
        held = (last_e - ref_e) % MODV;
        poll_expect(1, held, 1'b0, "R11 across empty");
        ref_e = last_e;

        // R9 poll while divider busy is queued
        edge_gap(20); edge_gap(20);
        held = ((last_e - ref_e) % MODV) / 2;
        ref_e = last_e;
        @(negedge clk); poll = 1'b1;
        @(negedge clk);
        @(negedge clk); poll = 1'b0;
        wait_valid(got);
        chk(got && !no_edge && ecnt == 2 && int'(period) == held, "R9 first",
            int'(period), held);
        @(negedge clk);
        wait_valid(got);
        chk(got && no_edge && ecnt == 0, "R9 queued", int'(no_edge), 1);
        @(negedge clk);

        // R3 saturation and sticky overflow
        chk(!ovf, "R3 no overflow yet", int'(ovf), 0);
        for (int e = 0; e < 20; e++) edge_gap(7);
        held = ((last_e - ref_e) % MODV) / 15;
        poll_expect(15, held, 1'b0, "R3 saturate");
        chk(ovf, "R3 overflow set", int'(ovf), 1);
        ref_e = last_e;
        poll_expect(0, held, 1'b1, "R3 after");
        chk(ovf, "R3 overflow sticky", int'(ovf), 1);

        // R4 internal tick interval on second instance
        for (int i = 0; i < 200 && !t_valid; i++) @(negedge clk);
        t1 = cyc;
        chk(t_valid && t_no_edge, "R4 tick result", int'(t_no_edge), 1);
        @(negedge clk);
        for (int i = 0; i < 200 && !t_valid; i++) @(negedge clk);
        chk(t_valid && (cyc - t1) == 50, "R4 tick interval", cyc - t1, 50);

        // R10 no consecutive result pulses seen
        chk(back_to_back == 0, "R10 pulse", back_to_back, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule